// File: doc/BRIEF.md
# Veto-Aware Event Derandomizer Packer

This block buffers the per-crossing event records of a front-end channel and packs them tightly into 80-bit link frames. Each event is stored as one 16-bit header word followed by its payload. Each payload word is 32 bits wide and occupies two 16-bit buffer slots. Stored words leave the buffer in arrival order, five to a frame, and no padding is placed between events. One crossing spans two clock cycles and the block can emit one frame per clock, so the readout capacity is two frames (ten words) per crossing. An event of more than ten words makes the backlog grow. An event of ten words or fewer keeps it steady or shrinks it.

A crossing flagged with the bunch-crossing veto, or with header-only mode, stores only its header and discards the payload, which lets the buffer drain. If the free space cannot hold a full event, that event is cut down to its header, the header is flagged as truncated, and a truncation counter is incremented. When fewer than five words are stored, the block sends an idle frame.

Top module: `veto_event_packer`

## Requirements
- R1: After reset the block sends idle frames (`frame_is_data` low), the truncation counter reads 0 and the buffer is empty.
- R2: Every stored header word holds the truncation flag in bit 15, a 3-bit size code in bits 14:12 (the number of 32-bit payload words stored after it) and the 12-bit bunch ID in bits 11:0.
- R3: A stored event is its header followed by its payload words in index order. Payload word k comes from `ev_payload[32k+31:32k]` and is stored upper half first. Words are packed back to back across frame boundaries, and a frame carries its oldest word in bits 79:64.
- R4: On each clock edge where at least five words are stored (counted before that edge's write), the next clock period shows one data frame of the five oldest words. Otherwise that period shows an idle frame. Words written on an edge cannot leave on that same edge.
- R5: An event with `ev_veto` high stores only its header, with size code 0 and truncation flag 0. Its payload is discarded and the truncation counter does not change.
- R6: An event with `ev_hdr_only` high is treated exactly like a vetoed event.
- R7: A non-vetoed event needs 1 + 2*`ev_len` words. If that exceeds the free space (DEPTH minus stored words before the edge), the event stores only its header, with truncation flag 1 and size code 0, and `trunc_count` increments by one.
- R8: An idle frame consists of five copies of the idle word (16'hF7F7 by default). `frame_is_data` is low for idle frames and high for data frames.
- R9: The number of stored words never exceeds DEPTH, and stored words are never lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one crossing is two cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An event record is presented this cycle |
| ev_bxid | input | 12 | Bunch ID of the event |
| ev_len | input | 3 | Number of 32-bit payload words (0 to 7) |
| ev_payload | input | 224 | Payload words; word k in bits 32k+31:32k |
| ev_veto | input | 1 | Bunch-crossing veto: keep the header only |
| ev_hdr_only | input | 1 | Header-only mode: keep the header only |
| frame_data | output | 80 | Outgoing link frame, oldest word in bits 79:64 |
| frame_is_data | output | 1 | High for a data frame, low for an idle frame |
| trunc_count | output | 16 | Number of events truncated to their header |

## Verification
The assertions check on every cycle that occupancy stays within DEPTH, that a data frame appears only after an edge on which at least five words were stored, that idle frames carry the idle pattern, and that the truncation counter never moves by more than one per edge. The exact word order across frame boundaries, the header contents, the growth of the backlog under large events, the truncation decision at the fill edge and the drain under vetoes and header-only crossings can only be shown by the bench's reference queue, which is compared with the frame stream on every clock.

// File: rtl/veto_event_packer.sv
module veto_event_packer #(
  parameter int          DEPTH     = 256,
  parameter int          CNT_W     = 16,
  parameter logic [15:0] IDLE_WORD = 16'hF7F7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_valid,
  input  logic [11:0]  ev_bxid,
  input  logic [2:0]   ev_len,
  input  logic [223:0] ev_payload,
  input  logic         ev_veto,
  input  logic         ev_hdr_only,
  output logic [79:0]  frame_data,
  output logic         frame_is_data,
  output logic [15:0]  trunc_count
);
  localparam int WW    = 16;
  localparam int FW    = 5;
  localparam int MAXP  = 7;
  localparam int SLOTS = 1 + 2 * MAXP;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int NW    = $clog2(SLOTS + 1);

  logic [WW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic [CNT_W-1:0] tcnt;
  logic [WW-1:0]    wwords [SLOTS];
  logic [FW*WW-1:0] rframe;

  wire          rd_go    = count >= CW'(FW);
  wire          drop_pay = ev_veto | ev_hdr_only;
  wire [NW-1:0] need     = drop_pay ? NW'(1) : NW'(1) + NW'({ev_len, 1'b0});
  wire [CW-1:0] free     = CW'(DEPTH) - count;
  wire          trunc    = ev_valid && !drop_pay && (free < CW'(need));
  wire          keep_pay = ev_valid && !drop_pay && !trunc;
  wire [NW-1:0] wr_n     = !ev_valid ? '0 : (keep_pay ? need : NW'(1));
  wire [WW-1:0] header   = {trunc, keep_pay ? ev_len : 3'd0, ev_bxid};

  assign trunc_count = 16'(tcnt);

  always_comb begin
    wwords[0] = header;
    for (int k = 0; k < MAXP; k++) begin
      wwords[1 + 2*k] = ev_payload[32*k + 16 +: 16];
      wwords[2 + 2*k] = ev_payload[32*k +: 16];
    end
  end

  always_comb begin
    for (int i = 0; i < FW; i++)
      rframe[WW*(FW-1-i) +: WW] = mem[rd_ptr + AW'(i)];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++)
      if (NW'(i) < wr_n) mem[wr_ptr + AW'(i)] <= wwords[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr        <= '0;
      rd_ptr        <= '0;
      count         <= '0;
      tcnt          <= '0;
      frame_data    <= {FW{IDLE_WORD}};
      frame_is_data <= 1'b0;
    end else begin
      wr_ptr        <= wr_ptr + AW'(wr_n);
      rd_ptr        <= rd_ptr + (rd_go ? AW'(FW) : '0);
      count         <= count - (rd_go ? CW'(FW) : '0) + CW'(wr_n);
      tcnt          <= tcnt + CNT_W'(trunc);
      frame_data    <= rd_go ? rframe : {FW{IDLE_WORD}};
      frame_is_data <= rd_go;
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r4_frame_needs_words: assert property (@(posedge clk) disable iff (!rst_n)
    frame_is_data |-> $past(count) >= CW'(FW));

  a_r8_idle_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_is_data |-> frame_data == {FW{IDLE_WORD}});

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt == $past(tcnt)) || (tcnt == $past(tcnt) + CNT_W'(1)));

endmodule

// File: tb/test_veto_event_packer.sv
module test_veto_event_packer;
  localparam int DEPTH = 256;
  localparam logic [15:0] IDLE = 16'hF7F7;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         ev_valid = 0;
  logic [11:0]  ev_bxid = 0;
  logic [2:0]   ev_len = 0;
  logic [223:0] ev_payload = 0;
  logic         ev_veto = 0;
  logic         ev_hdr_only = 0;
  logic [79:0]  frame_data;
  logic         frame_is_data;
  logic [15:0]  trunc_count;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit running = 0;

  logic [15:0] q[$];
  logic [79:0] exp_frame = {5{IDLE}};
  logic        exp_is = 0;
  int          exp_trunc = 0;

  veto_event_packer #(.DEPTH(DEPTH)) i_veto_event_packer (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_bxid(ev_bxid),
    .ev_len(ev_len), .ev_payload(ev_payload), .ev_veto(ev_veto),
    .ev_hdr_only(ev_hdr_only), .frame_data(frame_data),
    .frame_is_data(frame_is_data), .trunc_count(trunc_count));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_frame = {5{IDLE}};
      exp_is = 0;
      exp_trunc = 0;
    end else begin
      int cnt;
      cnt = q.size();
      if (cnt >= 5) begin
        for (int i = 0; i < 5; i++) exp_frame[16*(4-i) +: 16] = q.pop_front();
        exp_is = 1;
      end else begin
        exp_frame = {5{IDLE}};
        exp_is = 0;
      end
      if (ev_valid) begin
        if (ev_veto || ev_hdr_only) begin
          q.push_back({1'b0, 3'd0, ev_bxid});
        end else if (1 + 2*int'(ev_len) > DEPTH - cnt) begin
          q.push_back({1'b1, 3'd0, ev_bxid});
          exp_trunc++;
        end else begin
          q.push_back({1'b0, ev_len, ev_bxid});
          for (int k = 0; k < int'(ev_len); k++) begin
            q.push_back(ev_payload[32*k + 16 +: 16]);
            q.push_back(ev_payload[32*k +: 16]);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (frame_is_data !== exp_is || frame_data !== exp_frame) begin
        errors++;
        $display("FAIL %s frame: got kind %b data %h, expected kind %b data %h",
                 cur_req, frame_is_data, frame_data, exp_is, exp_frame);
      end
      checks++;
      if (trunc_count !== 16'(exp_trunc)) begin
        errors++;
        $display("FAIL %s trunc_count: got %0d, expected %0d", cur_req, trunc_count, exp_trunc);
      end
    end
  end

  task automatic check(string req, bit ok, string what, int got, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d, expected %0d", req, what, got, expv);
    end
  endtask

  task automatic crossing(bit valid, int len, bit veto, bit ho);
    @(negedge clk);
    ev_valid    = valid;
    ev_len      = 3'(len);
    ev_veto     = veto;
    ev_hdr_only = ho;
    ev_bxid     = 12'($urandom);
    for (int k = 0; k < 7; k++) ev_payload[32*k +: 32] = $urandom;
    @(negedge clk);
    ev_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", frame_is_data == 0, "idle kind in reset", int'(frame_is_data), 0);
    check("R8", frame_data == {5{IDLE}}, "idle pattern in reset", int'(frame_data[15:0]), int'(IDLE));
    rst_n = 1;
    @(negedge clk);
    running = 1;
    check("R1", trunc_count == 0, "counter after reset", int'(trunc_count), 0);

    cur_req = "R3";
    for (int n = 0; n < 40; n++) crossing(1, n % 5, 0, 0);
    repeat (10) crossing(0, 0, 0, 0);
    check("R4", frame_is_data == 0 && q.size() < 5, "drained after small events", q.size(), 0);

    cur_req = "R2";
    for (int n = 0; n < 16; n++) crossing(1, n % 8, 0, 0);

    cur_req = "R7";
    for (int n = 0; n < 70; n++) crossing(1, 7, 0, 0);
    check("R7", exp_trunc > 0 && int'(trunc_count) == exp_trunc, "truncations on full",
          int'(trunc_count), exp_trunc);

    cur_req = "R5";
    for (int n = 0; n < 40; n++) crossing(1, 7, 1, 0);
    cur_req = "R6";
    for (int n = 0; n < 30; n++) crossing(1, 7, 0, 1);
    for (int n = 0; n < 10; n++) crossing(1, 7, n[0], !n[0]);
    repeat (5) crossing(0, 0, 0, 0);
    check("R5", q.size() < 5 && frame_is_data == 0, "drained by vetoes", q.size(), 0);

    cur_req = "R9";
    for (int n = 0; n < 200; n++) crossing(1, (n * 3) % 8, n % 7 == 0, n % 11 == 0);
    repeat (150) crossing(0, 0, 0, 0);
    cur_req = "R8";
    check("R8", frame_is_data == 0 && frame_data == {5{IDLE}}, "idle when empty",
          int'(frame_is_data), 0);
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule